// File: doc/BRIEF.md
# Receive Ring Frame Writer

The block receives Ethernet frames as a byte stream, one byte per clock, framed by start and end markers. It decides from the first six bytes, the destination address, whether the frame is wanted. It also checks at the start of the frame whether the receive ring has room and whether reception is halted. A wanted frame goes into a circular buffer in packet memory through a byte-wide write port. The buffer is made of 256-byte pages and runs from a start page up to, but not including, a stop page.

Each stored frame sits behind a four-byte header at the start of the current page. The header carries a receive status, the page where the next frame will begin, and the stored length. Frames shorter than 60 bytes are extended with zero bytes. Frame bytes roll over from the stop page back to the start page. When the header is complete, the block pulses a done strobe and presents the new current page, which the surrounding logic loads into its current-page register. Frames arriving while the block is still finishing the previous one are ignored. Frames must therefore be separated by at least 70 idle cycles.

Top module: `rxr_ring_writer`

## Requirements
- R1: A frame is accepted when at least one of these holds: promiscuous mode is on; all six destination bytes are 0xFF and broadcast accept is on; bit 0 of destination byte 0 is 1 and group accept is on; or destination byte i equals `cfg_station[8*i+7:8*i]` for all i from 0 to 5. Destination bytes missing from a frame shorter than six bytes count as zero.
- R2: A frame that is not accepted produces no memory write and no done strobe.
- R3: A frame whose first byte arrives while `cfg_stopped` is 1 is discarded without writes or done strobe.
- R4: With C the current page, B the boundary page and S and E the start and stop pages, the free space in pages is B−C when C<B and (E−S)−(C−B) otherwise. A frame is discarded when 256 times the free space is below 1518 bytes.
- R5: Frame byte k is written to address C·256+4+k. When that address reaches E·256, it is reduced by (E−S)·256.
- R6: When a frame has fewer than 60 bytes, bytes from its length up to index 59 are written as 0x00 at their R5 addresses.
- R7: The header goes to C·256+0..3. Byte 0 is the status: bit 0 is 1, bit 5 equals bit 0 of destination byte 0, and all other bits are 0. Byte 1 is the next page. Bytes 2 and 3 hold T = max(length,60)+4, low byte first.
- R8: The next page is C + floor((T+4+255)/256). When that reaches E, E−S is subtracted.
- R9: `rx_done` is high for exactly one cycle per stored frame, in the same cycle as the write of header byte 3, with `rx_next_pg` equal to the R8 page.
- R10: At most one byte is written per clock, in this order: frame bytes 6 onward as they arrive, then bytes 0 to 5, then padding, then header bytes 0 to 3. Each write appears one cycle after the clock edge that took the byte or step that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame byte present this cycle |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| cfg_start_pg | input | 8 | First page of the ring |
| cfg_stop_pg | input | 8 | Page after the last ring page |
| cfg_boundary | input | 8 | Oldest page still owned by the reader |
| cfg_cur_pg | input | 8 | Page where the next frame is stored |
| cfg_station | input | 48 | Station address, byte i at bits 8i+7:8i |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_en | input | 1 | Accept broadcast frames |
| cfg_mcast_en | input | 1 | Accept group-addressed frames |
| cfg_stopped | input | 1 | Reception halted |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| rx_done | output | 1 | One-cycle frame-stored strobe |
| rx_next_pg | output | 8 | New current page, valid with rx_done |

## Verification
Almost any fault in the internal state shows up as a write that differs from the reference stream. A wrong filter or space decision produces writes where none were expected, or leaves expected writes outstanding when the frame ends. A wrong offset, wrap or padding counter shows up as a bad address on the very write where it first goes wrong, within one cycle of the faulty step. A wrong length or next-page result appears only in header bytes 1 to 3 and on `rx_next_pg`. These come out at the end of the frame, no more than 64 cycles after its last byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned DA_BYTES  = 6;
  localparam int unsigned HDR_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_DRAIN,
    ST_TAIL,
    ST_HDR
  } rxr_state_e;
endpackage

// File: rtl/rxr_dest_filter.sv
module rxr_dest_filter #(
  parameter int unsigned NB = 6
) (
  input  logic [NB*8-1:0] dest_i,
  input  logic [NB*8-1:0] station_i,
  input  logic            promisc_i,
  input  logic            bcast_en_i,
  input  logic            mcast_en_i,
  output logic            accept_o,
  output logic            group_o
);
  logic [NB-1:0] byte_match;
  logic [NB-1:0] byte_ones;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign byte_match[g] = (dest_i[g*8 +: 8] == station_i[g*8 +: 8]);
    assign byte_ones[g]  = &dest_i[g*8 +: 8];
  end

  assign group_o  = dest_i[0];
  assign accept_o = promisc_i
                  | ((&byte_ones) & bcast_en_i)
                  | (group_o & mcast_en_i)
                  | (&byte_match);
endmodule

// File: rtl/rxr_space_check.sv
module rxr_space_check #(
  parameter int unsigned PG_W      = 8,
  parameter int unsigned MAX_FRAME = 1518
) (
  input  logic [PG_W-1:0] cur_i,
  input  logic [PG_W-1:0] bnd_i,
  input  logic [PG_W-1:0] start_i,
  input  logic [PG_W-1:0] stop_i,
  output logic            room_ok_o
);
  localparam int unsigned FREE_W = PG_W + 9;

  logic [PG_W:0]   ring_pg;
  logic [PG_W:0]   free_pg;
  logic [FREE_W-1:0] free_bytes;

  always_comb begin
    ring_pg = {1'b0, stop_i} - {1'b0, start_i};
    if (cur_i < bnd_i) free_pg = {1'b0, bnd_i} - {1'b0, cur_i};
    else               free_pg = ring_pg - ({1'b0, cur_i} - {1'b0, bnd_i});
    free_bytes = {free_pg, 8'h00};
    room_ok_o  = (free_bytes >= FREE_W'(MAX_FRAME));
  end
endmodule

// File: rtl/rxr_ring_addr.sv
module rxr_ring_addr #(
  parameter int unsigned PG_W  = 8,
  parameter int unsigned OFF_W = 16
) (
  input  logic [PG_W-1:0]  page_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [PG_W-1:0]  start_i,
  input  logic [PG_W-1:0]  stop_i,
  output logic [PG_W+7:0]  addr_o
);
  localparam int unsigned SUM_W = ((OFF_W > PG_W + 8) ? OFF_W : PG_W + 8) + 1;

  logic [SUM_W-1:0] raw;
  logic [SUM_W-1:0] limit;
  logic [SUM_W-1:0] ring_b;
  logic [SUM_W-1:0] fixed;
  logic             unused_hi;

  always_comb begin
    raw    = SUM_W'({page_i, 8'h00}) + SUM_W'(off_i);
    limit  = SUM_W'({stop_i, 8'h00});
    ring_b = SUM_W'({stop_i - start_i, 8'h00});
    fixed  = (raw >= limit) ? (raw - ring_b) : raw;
  end

  assign addr_o    = fixed[PG_W+7:0];
  assign unused_hi = ^fixed[SUM_W-1:PG_W+8];
endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
  parameter int unsigned PG_W    = 8,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MIN_LEN = 60
) (
  input  logic [PG_W-1:0]  page_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PG_W-1:0]  start_i,
  input  logic [PG_W-1:0]  stop_i,
  output logic [PG_W-1:0]  next_pg_o,
  output logic [LEN_W-1:0] total_o
);
  localparam int unsigned W = ((LEN_W > PG_W) ? LEN_W : PG_W) + 2;

  logic [W-1:0] padded;
  logic [W-1:0] total;
  logic [W-1:0] pages;
  logic [W-1:0] nraw;
  logic [W-1:0] nfix;
  logic         unused_bits;

  always_comb begin
    padded = (len_i < LEN_W'(MIN_LEN)) ? W'(MIN_LEN) : W'(len_i);
    total  = padded + W'(4);
    pages  = (total + W'(4) + W'(255)) >> 8;
    nraw   = W'(page_i) + pages;
    nfix   = (nraw >= W'(stop_i)) ? (nraw - (W'(stop_i) - W'(start_i))) : nraw;
  end

  assign next_pg_o   = nfix[PG_W-1:0];
  assign total_o     = total[LEN_W-1:0];
  assign unused_bits = ^{nfix[W-1:PG_W], total[W-1:LEN_W]};
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned PG_W      = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MIN_LEN   = 60,
  parameter int unsigned MAX_FRAME = 1518
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sop,
  input  logic                  in_eop,
  input  logic [7:0]            in_data,
  input  logic [PG_W-1:0]       cfg_start_pg,
  input  logic [PG_W-1:0]       cfg_stop_pg,
  input  logic [PG_W-1:0]       cfg_boundary,
  input  logic [PG_W-1:0]       cfg_cur_pg,
  input  logic [DA_BYTES*8-1:0] cfg_station,
  input  logic                  cfg_promisc,
  input  logic                  cfg_bcast_en,
  input  logic                  cfg_mcast_en,
  input  logic                  cfg_stopped,
  output logic                  mem_we,
  output logic [PG_W+7:0]       mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  rx_done,
  output logic [PG_W-1:0]       rx_next_pg
);
  localparam int unsigned NB     = DA_BYTES;
  localparam int unsigned ADDR_W = PG_W + 8;
  localparam int unsigned TIDX_W = $clog2(MIN_LEN + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_q_n <= rst_s0;
    end
  end

  rxr_state_e         state_q, state_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [NB*8-1:0]    dest_q, dest_d;
  logic               acc_q, acc_d;
  logic [PG_W-1:0]    cur_q, cur_d;
  logic [PG_W-1:0]    start_q, start_d;
  logic [PG_W-1:0]    stop_q, stop_d;
  logic [TIDX_W-1:0]  tidx_q, tidx_d;
  logic [1:0]         hidx_q, hidx_d;
  logic               we_q, we_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [7:0]         wdata_q, wdata_d;
  logic               done_q, done_d;
  logic [PG_W-1:0]    npg_q, npg_d;

  logic               take;
  logic [LEN_W-1:0]   idx;
  logic [NB*8-1:0]    view;
  logic               decide_now;
  logic               filt_acc, filt_grp;
  logic               room_ok;
  logic [LEN_W-1:0]   ring_off;
  logic [ADDR_W-1:0]  ring_addr;
  logic [PG_W-1:0]    calc_next;
  logic [LEN_W-1:0]   calc_total;
  logic [7:0]         tail_byte;
  logic               unused_grp;

  assign take = in_valid && ((state_q == ST_IDLE) ? in_sop : (state_q == ST_RECV));
  assign idx  = (state_q == ST_IDLE) ? '0 : cnt_q;

  // destination bytes as seen including the byte arriving now
  always_comb begin
    view = dest_q;
    for (int i = 0; i < NB; i++) begin
      if (state_q == ST_IDLE)              view[i*8 +: 8] = (i == 0) ? in_data : 8'h00;
      else if (take && idx == LEN_W'(i))   view[i*8 +: 8] = in_data;
    end
  end

  assign decide_now = take && ((idx == LEN_W'(NB-1)) || (in_eop && idx < LEN_W'(NB-1)));

  rxr_dest_filter #(.NB(NB)) u_filter (
    .dest_i     (view),
    .station_i  (cfg_station),
    .promisc_i  (cfg_promisc),
    .bcast_en_i (cfg_bcast_en),
    .mcast_en_i (cfg_mcast_en),
    .accept_o   (filt_acc),
    .group_o    (filt_grp)
  );
  assign unused_grp = filt_grp;

  rxr_space_check #(.PG_W(PG_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .cur_i     (cfg_cur_pg),
    .bnd_i     (cfg_boundary),
    .start_i   (cfg_start_pg),
    .stop_i    (cfg_stop_pg),
    .room_ok_o (room_ok)
  );

  assign ring_off = LEN_W'(HDR_BYTES) + ((state_q == ST_TAIL) ? LEN_W'(tidx_q) : idx);

  rxr_ring_addr #(.PG_W(PG_W), .OFF_W(LEN_W)) u_addr (
    .page_i  (cur_q),
    .off_i   (ring_off),
    .start_i (start_q),
    .stop_i  (stop_q),
    .addr_o  (ring_addr)
  );

  rxr_next_page #(.PG_W(PG_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_next (
    .page_i    (cur_q),
    .len_i     (len_q),
    .start_i   (start_q),
    .stop_i    (stop_q),
    .next_pg_o (calc_next),
    .total_o   (calc_total)
  );

  always_comb begin
    tail_byte = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (tidx_q == TIDX_W'(i)) tail_byte = dest_q[i*8 +: 8];
    end
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    dest_d  = dest_q;
    acc_d   = acc_q;
    cur_d   = cur_q;
    start_d = start_q;
    stop_d  = stop_q;
    tidx_d  = tidx_q;
    hidx_d  = hidx_q;
    we_d    = 1'b0;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    done_d  = 1'b0;
    npg_d   = npg_q;

    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          cur_d   = cfg_cur_pg;
          start_d = cfg_start_pg;
          stop_d  = cfg_stop_pg;
          dest_d  = view;
          cnt_d   = LEN_W'(1);
          acc_d   = decide_now ? filt_acc : 1'b0;
          tidx_d  = '0;
          hidx_d  = '0;
          if (cfg_stopped || !room_ok) begin
            state_d = in_eop ? ST_IDLE : ST_DRAIN;
          end else if (in_eop) begin
            len_d   = LEN_W'(1);
            state_d = filt_acc ? ST_TAIL : ST_IDLE;
          end else begin
            state_d = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (take) begin
          dest_d = view;
          cnt_d  = cnt_q + LEN_W'(1);
          if (decide_now) acc_d = filt_acc;
          if (idx >= LEN_W'(NB) && acc_q) begin
            we_d    = 1'b1;
            addr_d  = ring_addr;
            wdata_d = in_data;
          end
          if (in_eop) begin
            len_d   = idx + LEN_W'(1);
            tidx_d  = '0;
            state_d = (decide_now ? filt_acc : acc_q) ? ST_TAIL : ST_IDLE;
          end
        end
      end
      ST_DRAIN: begin
        if (in_valid && in_eop) state_d = ST_IDLE;
      end
      ST_TAIL: begin
        we_d    = 1'b1;
        addr_d  = ring_addr;
        wdata_d = tail_byte;
        if (tidx_q == TIDX_W'(NB-1)) begin
          if (len_q >= LEN_W'(MIN_LEN))  state_d = ST_HDR;
          else if (len_q > LEN_W'(NB))   tidx_d  = TIDX_W'(len_q);
          else                           tidx_d  = TIDX_W'(NB);
        end else if (tidx_q >= TIDX_W'(MIN_LEN-1)) begin
          state_d = ST_HDR;
        end else begin
          tidx_d = tidx_q + TIDX_W'(1);
        end
      end
      ST_HDR: begin
        we_d   = 1'b1;
        addr_d = {cur_q, 6'b000000, hidx_q};
        unique case (hidx_q)
          2'd0:    wdata_d = {2'b00, dest_q[0], 4'b0000, 1'b1};
          2'd1:    wdata_d = 8'(calc_next);
          2'd2:    wdata_d = calc_total[7:0];
          default: wdata_d = 8'(calc_total >> 8);
        endcase
        hidx_d = hidx_q + 2'd1;
        if (hidx_q == 2'd3) begin
          done_d  = 1'b1;
          npg_d   = calc_next;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      dest_q  <= '0;
      acc_q   <= 1'b0;
      cur_q   <= '0;
      start_q <= '0;
      stop_q  <= '0;
      tidx_q  <= '0;
      hidx_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      npg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      dest_q  <= dest_d;
      acc_q   <= acc_d;
      cur_q   <= cur_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      tidx_q  <= tidx_d;
      hidx_q  <= hidx_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      done_q  <= done_d;
      npg_q   <= npg_d;
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign rx_done    = done_q;
  assign rx_next_pg = npg_q;

  // R5: every write lands inside the ring captured for the frame
  a_r5_write_in_ring: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_we |-> (mem_addr >= {start_q, 8'h00}) && (mem_addr < {stop_q, 8'h00}));

  // R9: the done strobe lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_done |=> !rx_done);

  // R8: the reported page stays inside the ring
  a_r8_next_in_ring: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_done |-> (rx_next_pg >= start_q) && (rx_next_pg < stop_q));

  // R7, R9: done coincides with the write of header byte 3
  a_r7_done_with_hdr: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_done |-> mem_we && (mem_addr == {cur_q, 8'h03}));

  // R3: a frame started while halted causes no write in the next cycle
  a_r3_stopped_no_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_IDLE && in_valid && in_sop && cfg_stopped) |=> !mem_we && !rx_done);

  // R2: nothing is written while a discarded frame drains
  a_r2_drain_silent: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_DRAIN) |-> !mem_we && !rx_done);
endmodule

// File: tb/rxr_ring_writer_tb.sv
module rxr_ring_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop;
  logic [7:0]  in_data;
  logic [7:0]  cfg_start_pg, cfg_stop_pg, cfg_boundary, cfg_cur_pg;
  logic [47:0] cfg_station;
  logic        cfg_promisc, cfg_bcast_en, cfg_mcast_en, cfg_stopped;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rx_done;
  logic [7:0]  rx_next_pg;

  always #2.5 clk = ~clk;

  rxr_ring_writer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg),
    .cfg_boundary(cfg_boundary), .cfg_cur_pg(cfg_cur_pg), .cfg_station(cfg_station),
    .cfg_promisc(cfg_promisc), .cfg_bcast_en(cfg_bcast_en), .cfg_mcast_en(cfg_mcast_en),
    .cfg_stopped(cfg_stopped), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rx_done(rx_done), .rx_next_pg(rx_next_pg)
  );

  int n_checks = 0;
  int n_err = 0;
  bit chk_en = 1'b0;
  bit all_done = 1'b0;
  int exp_addr[$];
  int exp_data[$];
  string exp_tag[$];
  int exp_pg[$];
  logic [7:0] fb [0:2047];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // per-cycle comparison against the reference write stream
  always @(negedge clk) begin
    if (chk_en) begin
      if (mem_we) begin
        if (exp_addr.size() == 0) chk(1'b0, "R2", "unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          int a, d; string t;
          a = exp_addr.pop_front(); d = exp_data.pop_front(); t = exp_tag.pop_front();
          chk(mem_addr == a[15:0] && mem_wdata == d[7:0], t, "write addr/data",
              {mem_addr, mem_wdata}, {a[15:0], d[7:0]});
        end
      end
      if (rx_done) begin
        if (exp_pg.size() == 0) chk(1'b0, "R9", "unexpected done", rx_next_pg, 0);
        else begin
          int p;
          p = exp_pg.pop_front();
          chk(rx_next_pg == p[7:0], "R8", "next page", rx_next_pg, p);
          chk(mem_we && mem_addr == {cfg_cur_pg, 8'h03}, "R9", "done with last header write",
              mem_addr, {cfg_cur_pg, 8'h03});
        end
      end
    end
  end

  function automatic int wrapa(input int a);
    int lim, ring;
    lim = int'(cfg_stop_pg) * 256;
    ring = (int'(cfg_stop_pg) - int'(cfg_start_pg)) * 256;
    return (a >= lim) ? a - ring : a;
  endfunction

  task automatic push(input int a, input int d, input string t);
    exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  task automatic fill(input logic [47:0] da, input int n, input int seed);
    for (int i = 0; i < n; i++) fb[i] = (i < 6) ? da[i*8 +: 8] : 8'((i * 7 + seed) & 255);
  endtask

  // reference model plus driver for one frame
  task automatic run_frame(input int n, input bit bubble, input string tag);
    logic [7:0] d [0:5];
    bit allff, match, acc;
    int c, b, s, e, freep, base, L, T, nxt;
    for (int i = 0; i < 6; i++) d[i] = (i < n) ? fb[i] : 8'h00;
    allff = 1'b1; match = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (d[i] != 8'hFF) allff = 1'b0;
      if (d[i] != cfg_station[i*8 +: 8]) match = 1'b0;
    end
    acc = cfg_promisc || (allff && cfg_bcast_en) || (d[0][0] && cfg_mcast_en) || match;
    c = cfg_cur_pg; b = cfg_boundary; s = cfg_start_pg; e = cfg_stop_pg;
    freep = (c < b) ? (b - c) : ((e - s) - (c - b));
    if (acc && !cfg_stopped && freep * 256 >= 1518) begin
      base = c * 256 + 4;
      for (int k = 6; k < n; k++) push(wrapa(base + k), fb[k], "R5");
      for (int k = 0; k < 6; k++) push(wrapa(base + k), d[k], "R5");
      for (int k = (n > 6 ? n : 6); k < 60; k++) push(wrapa(base + k), 0, "R6");
      L = (n < 60) ? 60 : n;
      T = L + 4;
      nxt = c + (T + 4 + 255) / 256;
      if (nxt >= e) nxt -= (e - s);
      push(c * 256 + 0, {2'b00, d[0][0], 4'b0000, 1'b1}, "R7");
      push(c * 256 + 1, nxt, "R7");
      push(c * 256 + 2, T & 255, "R7");
      push(c * 256 + 3, (T >> 8) & 255, "R7");
      exp_pg.push_back(nxt);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bubble && (i % 7 == 3)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == n - 1); in_data = fb[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    repeat (100) @(negedge clk);
    chk(exp_addr.size() == 0, tag, "writes outstanding after frame", exp_addr.size(), 0);
    chk(exp_pg.size() == 0, tag, "done strobes outstanding", exp_pg.size(), 0);
    exp_addr.delete(); exp_data.delete(); exp_tag.delete(); exp_pg.delete();
  endtask

  localparam logic [47:0] STATION = {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h02};

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
    cfg_start_pg = 8'h40; cfg_stop_pg = 8'h60; cfg_boundary = 8'h40; cfg_cur_pg = 8'h40;
    cfg_station = STATION;
    cfg_promisc = 1'b0; cfg_bcast_en = 1'b0; cfg_mcast_en = 1'b0; cfg_stopped = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem_we == 1'b0, "R10", "reset write strobe", mem_we, 0);
    chk(rx_done == 1'b0, "R9", "reset done strobe", rx_done, 0);
    chk_en = 1'b1;

    // R1: exact station match
    fill(STATION, 64, 1); run_frame(64, 1'b0, "R1");
    // R2: one byte differs from the station address
    fill(STATION ^ 48'h010000000000, 64, 2); run_frame(64, 1'b0, "R2");
    // R1: broadcast, accepted
    cfg_cur_pg = 8'h41; cfg_bcast_en = 1'b1;
    fill(48'hFFFFFFFFFFFF, 100, 3); run_frame(100, 1'b0, "R1");
    // R2: broadcast with both group accepts off
    cfg_bcast_en = 1'b0;
    fill(48'hFFFFFFFFFFFF, 80, 4); run_frame(80, 1'b0, "R2");
    // R1: group address with bubbles in the stream
    cfg_mcast_en = 1'b1; cfg_cur_pg = 8'h43;
    fill(48'h0000005E0001, 90, 5); run_frame(90, 1'b1, "R1");
    cfg_mcast_en = 1'b0;
    // R1: promiscuous with a foreign address
    cfg_promisc = 1'b1; cfg_cur_pg = 8'h44;
    fill(48'hABCDEF123456, 70, 6); run_frame(70, 1'b0, "R1");
    // R6: three-byte frame in promiscuous mode
    fill(48'h0, 3, 7); run_frame(3, 1'b0, "R6");
    cfg_promisc = 1'b0;
    // R6: ten-byte unicast frame
    cfg_cur_pg = 8'h45;
    fill(STATION, 10, 8); run_frame(10, 1'b0, "R6");
    // R8: page rounding at the 248/249 byte border
    cfg_cur_pg = 8'h46; fill(STATION, 248, 9); run_frame(248, 1'b0, "R8");
    cfg_cur_pg = 8'h47; fill(STATION, 249, 10); run_frame(249, 1'b0, "R8");
    // R5, R8: frame wraps past the stop page
    cfg_cur_pg = 8'h5F; cfg_boundary = 8'h50;
    fill(STATION, 300, 11); run_frame(300, 1'b1, "R5");
    // R4: five free pages, discarded
    cfg_cur_pg = 8'h45; cfg_boundary = 8'h4A;
    fill(STATION, 64, 12); run_frame(64, 1'b0, "R4");
    // R4: six free pages, stored
    cfg_boundary = 8'h4B;
    fill(STATION, 64, 13); run_frame(64, 1'b0, "R4");
    // R3: halted
    cfg_stopped = 1'b1; cfg_boundary = 8'h40; cfg_cur_pg = 8'h40;
    fill(STATION, 64, 14); run_frame(64, 1'b0, "R3");
    cfg_stopped = 1'b0;
    // R10: the write order holds again after a discarded frame
    fill(STATION, 61, 15); run_frame(61, 1'b0, "R10");

    all_done = 1'b1;
    summary();
  end
endmodule